// File: doc/BRIEF.md
# Display Link Training Sequencer

This block runs the two-phase bring-up of a multi-lane serial display link. A one-cycle `start` pulse selects the starting link rate and lane count from the source and sink capabilities. The block then runs clock recovery, and after that channel equalization. It polls an abstract sink-status port after a programmable wait, and it issues training-pattern and lane-drive updates on an outgoing write stream. When either phase fails, the block drops to the next lower rate and starts again from clock recovery. Whatever the outcome, it ends by disabling the training pattern. It then reports `done` or `fail` together with the rate it used.

Training updates leave the block on a valid/ready stream. A beat is taken on a rising edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the beat and all of its fields stay unchanged. The block never withdraws a beat it has offered. Sink status comes back through a request/grant pair. `st_req` stays high until the first edge on which `st_gnt` is high, and the status inputs are sampled on that edge only. The block never offers a write beat and a status request in the same cycle.

The sink-status side reduces the per-lane adjust requests to one value before they reach this block. `st_swing` carries the highest voltage swing that any active lane asks for. The drive-level encoding and the physical link are outside this block.

Top module: `lt_train_seq`

## Requirements
- R1: On `start`, the rate code becomes the numerically smaller of `src_max_rate` and `snk_max_rate`, and the lane count becomes the smaller of `src_lanes` and `snk_lanes`. Both values appear on `link_rate` and `link_lanes`, and `done` and `fail` clear.
- R2: Write beats are held stable while stalled. `wr_kind` is encoded as 0 = pattern plus lane settings, 1 = lane settings only, 2 = pattern only. `wr_pattern` is encoded as 0 = disabled, 1/2/3 = training pattern 1/2/3 (scrambling off). `pattern` shows the pattern of the last accepted beat.
- R3: Every clock-recovery attempt opens with a kind-0 beat that carries pattern 1 and swing 0, sent at the current rate.
- R4: A status request rises `wait_cycles`+1 clock cycles after the edge that accepts any kind-0 or kind-1 beat. It is held until granted.
- R5: Clock recovery passes when `st_cr_lock` is set on every active lane. Bits of lanes at or above the lane count are ignored.
- R6: On a clock-recovery miss, the requested swing is clamped to 2 and sent as a kind-1 beat. A same-swing counter restarts at 1 whenever the clamped swing differs from the previous one, and otherwise increments. A miss while the counter is at 5 fails the phase.
- R7: A request of swing 2 or more marks max swing. The next status read that shows no lock fails the phase.
- R8: Equalization opens with a kind-0 beat that carries the current swing, with pattern 3 if `snk_tps3` is set and pattern 2 otherwise.
- R9: During equalization, a read with lock missing on any active lane fails the phase. A read with `st_eq_ok` set on all active lanes succeeds. Otherwise a kind-1 beat follows, except after the fifth unsuccessful read, which fails the phase with no beat.
- R10: A granted read with `st_err` high fails the current phase.
- R11: A phase failure moves the rate 0x14 to 0x0A and 0x0A to 0x06, and maps any other code except 0x06 to 0x14, then restarts at R3. A failure at 0x06 is final.
- R12: Training ends with a kind-2 beat carrying pattern 0. On the edge that accepts it, exactly one of `done` (success) or `fail` rises. That flag is held until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin training (taken when idle) |
| src_max_rate | input | 8 | Source maximum rate code |
| snk_max_rate | input | 8 | Sink maximum rate code |
| src_lanes | input | 3 | Source lane count |
| snk_lanes | input | 3 | Sink lane count |
| snk_tps3 | input | 1 | Sink supports training pattern 3 |
| wait_cycles | input | 16 | Wait between an update and the next poll |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Write beat accepted |
| wr_kind | output | 2 | Beat kind (R2) |
| wr_pattern | output | 2 | Training pattern of the beat |
| wr_swing | output | 2 | Lane swing setting of the beat |
| st_req | output | 1 | Status read request |
| st_gnt | input | 1 | Status read grant |
| st_err | input | 1 | Status read error |
| st_cr_lock | input | 4 | Per-lane clock lock |
| st_eq_ok | input | 4 | Per-lane equalization done |
| st_swing | input | 2 | Highest swing requested by any lane |
| done | output | 1 | Training succeeded |
| fail | output | 1 | Training failed |
| link_rate | output | 8 | Current rate code |
| link_lanes | output | 3 | Trained lane count |
| pattern | output | 2 | Current training pattern |

## Verification
Each write beat is compared with the model's next expected beat in the cycle the handshake completes. That comparison covers kind, pattern, swing and the rate shown beside it. The status request is due exactly `wait_cycles`+2 falling edges after the falling edge where the accepting handshake was seen, and the bench counts edges to confirm that. The `pattern`, `done` and `fail` outputs take their new values one cycle after the beat that changes them. The model applies its own update at that same point and compares all three on every falling edge. The bench grants each read on the second cycle of the request and stalls one write cycle in three, so both hold rules are exercised.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam logic [7:0] RATE_LO  = 8'h06;
  localparam logic [7:0] RATE_MID = 8'h0A;
  localparam logic [7:0] RATE_HI  = 8'h14;

  typedef enum logic [1:0] {
    WR_PAT_LANES = 2'd0,
    WR_LANES     = 2'd1,
    WR_PAT_ONLY  = 2'd2
  } wr_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CR_START, S_WAIT, S_READ, S_CR_UPD, S_EQ_START, S_EQ_UPD, S_STOP
  } seq_state_e;

  function automatic logic [7:0] rate_step_down(input logic [7:0] r);
    case (r)
      RATE_HI:  return RATE_MID;
      RATE_MID: return RATE_LO;
      default:  return RATE_HI;
    endcase
  endfunction
endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - TW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/lt_lane_check.sv
module lt_lane_check #(
  parameter int NLANES = 4,
  parameter int LW     = 3
) (
  input  logic [LW-1:0]     lanes,
  input  logic [NLANES-1:0] bits,
  output logic              all_ok
);
  logic [NLANES-1:0] lane_ok;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    assign lane_ok[i] = bits[i] | (LW'(i) >= lanes);
  end

  assign all_ok = &lane_ok;
endmodule

// File: rtl/lt_train_seq.sv
module lt_train_seq
  import lt_pkg::*;
#(
  parameter int NLANES     = 4,
  parameter int TW         = 16,
  parameter int SAME_LIMIT = 5,
  parameter int EQ_LIMIT   = 5,
  parameter int SWING_MAX  = 2,
  localparam int LW = $clog2(NLANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        src_max_rate,
  input  logic [7:0]        snk_max_rate,
  input  logic [LW-1:0]     src_lanes,
  input  logic [LW-1:0]     snk_lanes,
  input  logic              snk_tps3,
  input  logic [TW-1:0]     wait_cycles,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [1:0]        wr_kind,
  output logic [1:0]        wr_pattern,
  output logic [1:0]        wr_swing,
  output logic              st_req,
  input  logic              st_gnt,
  input  logic              st_err,
  input  logic [NLANES-1:0] st_cr_lock,
  input  logic [NLANES-1:0] st_eq_ok,
  input  logic [1:0]        st_swing,
  output logic              done,
  output logic              fail,
  output logic [7:0]        link_rate,
  output logic [LW-1:0]     link_lanes,
  output logic [1:0]        pattern
);
  localparam int CW = $clog2(SAME_LIMIT + 1);
  localparam int EW = $clog2(EQ_LIMIT + 1);
  localparam logic [1:0] SW_CAP = 2'(SWING_MAX);

  seq_state_e      state_q;
  logic            phase_eq_q, maxsw_q, ok_q, done_q, fail_q;
  logic [7:0]      rate_q;
  logic [LW-1:0]   lanes_q;
  logic [1:0]      swing_q, pat_q;
  logic [CW-1:0]   same_q;
  logic [EW-1:0]   tries_q;

  logic       cr_all, eq_all, tmr_exp, wr_fire, rd_fire, rd_pass, rd_fail, sw_top;
  logic [1:0] sw_clamp, eq_pat;
  wr_kind_e   kind_c;

  lt_lane_check #(.NLANES(NLANES), .LW(LW)) u_cr_chk (
    .lanes(lanes_q), .bits(st_cr_lock), .all_ok(cr_all));
  lt_lane_check #(.NLANES(NLANES), .LW(LW)) u_eq_chk (
    .lanes(lanes_q), .bits(st_eq_ok), .all_ok(eq_all));
  lt_wait_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(wr_fire && (state_q != S_STOP)),
    .load_val(wait_cycles), .expired(tmr_exp));

  assign sw_top   = (st_swing >= SW_CAP);
  assign sw_clamp = sw_top ? SW_CAP : st_swing;
  assign eq_pat   = snk_tps3 ? 2'd3 : 2'd2;

  // Write stream fields per state
  always_comb begin
    wr_valid   = 1'b1;
    kind_c     = WR_LANES;
    wr_pattern = pat_q;
    wr_swing   = swing_q;
    case (state_q)
      S_CR_START: begin kind_c = WR_PAT_LANES; wr_pattern = 2'd1; wr_swing = 2'd0; end
      S_EQ_START: begin kind_c = WR_PAT_LANES; wr_pattern = eq_pat; end
      S_CR_UPD, S_EQ_UPD: kind_c = WR_LANES;
      S_STOP:     begin kind_c = WR_PAT_ONLY; wr_pattern = 2'd0; wr_swing = 2'd0; end
      default:    wr_valid = 1'b0;
    endcase
  end

  assign wr_kind = kind_c;
  assign wr_fire = wr_valid && wr_ready;
  assign st_req  = (state_q == S_READ);
  assign rd_fire = st_req && st_gnt;

  // Outcome of a granted status read
  always_comb begin
    if (!phase_eq_q) begin
      rd_pass = !st_err && cr_all;
      rd_fail = st_err || (!cr_all && ((same_q >= CW'(SAME_LIMIT)) || maxsw_q));
    end else begin
      rd_pass = !st_err && cr_all && eq_all;
      rd_fail = st_err || !cr_all || (!eq_all && (tries_q == EW'(EQ_LIMIT - 1)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      phase_eq_q <= 1'b0;
      maxsw_q    <= 1'b0;
      ok_q       <= 1'b0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      rate_q     <= '0;
      lanes_q    <= '0;
      swing_q    <= '0;
      pat_q      <= '0;
      same_q     <= '0;
      tries_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          rate_q  <= (src_max_rate < snk_max_rate) ? src_max_rate : snk_max_rate;
          lanes_q <= (src_lanes < snk_lanes) ? src_lanes : snk_lanes;
          done_q  <= 1'b0;
          fail_q  <= 1'b0;
          state_q <= S_CR_START;
        end
        S_CR_START: if (wr_fire) begin
          pat_q      <= 2'd1;
          swing_q    <= 2'd0;
          same_q     <= CW'(1);
          maxsw_q    <= 1'b0;
          phase_eq_q <= 1'b0;
          state_q    <= S_WAIT;
        end
        S_EQ_START: if (wr_fire) begin
          pat_q      <= eq_pat;
          tries_q    <= '0;
          phase_eq_q <= 1'b1;
          state_q    <= S_WAIT;
        end
        S_CR_UPD, S_EQ_UPD: if (wr_fire) state_q <= S_WAIT;
        S_WAIT: if (tmr_exp) state_q <= S_READ;
        S_READ: if (rd_fire) begin
          if (rd_fail) begin
            if (rate_q == RATE_LO) begin
              ok_q    <= 1'b0;
              state_q <= S_STOP;
            end else begin
              rate_q  <= rate_step_down(rate_q);
              state_q <= S_CR_START;
            end
          end else if (rd_pass) begin
            if (!phase_eq_q) state_q <= S_EQ_START;
            else begin
              ok_q    <= 1'b1;
              state_q <= S_STOP;
            end
          end else begin
            swing_q <= sw_clamp;
            if (!phase_eq_q) begin
              same_q  <= (sw_clamp == swing_q) ? same_q + CW'(1) : CW'(1);
              maxsw_q <= sw_top;
              state_q <= S_CR_UPD;
            end else begin
              tries_q <= tries_q + EW'(1);
              state_q <= S_EQ_UPD;
            end
          end
        end
        S_STOP: if (wr_fire) begin
          pat_q   <= 2'd0;
          done_q  <= ok_q;
          fail_q  <= !ok_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign fail       = fail_q;
  assign link_rate  = rate_q;
  assign link_lanes = lanes_q;
  assign pattern    = pat_q;
endmodule

// File: rtl/lt_seq_chk.sv
module lt_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       fail,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [1:0] wr_kind,
  input logic [1:0] wr_pattern,
  input logic [1:0] wr_swing,
  input logic       st_req,
  input logic       st_gnt
);
  // R12
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_kind) &&
                                 $stable(wr_pattern) && $stable(wr_swing)));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !st_gnt) |=> st_req);

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && st_req));

  // R12
  disable_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_pattern == 2'd0)) |-> (wr_kind == 2'd2));

  // R6
  swing_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_swing <= 2'd2));

  // R12
  stop_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && (wr_kind == 2'd2)) |=> (done || fail));
endmodule

bind lt_train_seq lt_seq_chk u_seq_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .fail(fail),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_kind(wr_kind),
  .wr_pattern(wr_pattern), .wr_swing(wr_swing),
  .st_req(st_req), .st_gnt(st_gnt));

// File: tb/tb_lt_train_seq.sv
module tb_lt_train_seq;
  typedef struct packed { logic err; logic [3:0] cr; logic [3:0] eq; logic [1:0] sw; } resp_t;
  typedef struct packed { logic [1:0] kind; logic [1:0] pat; logic [1:0] sw; logic [7:0] rate; } wexp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] src_max_rate = 8'h14, snk_max_rate = 8'h14;
  logic [2:0] src_lanes = 3'd4, snk_lanes = 3'd4;
  logic snk_tps3 = 1'b0;
  logic [15:0] wait_cycles = 16'd3;
  logic wr_valid, wr_ready = 1'b0;
  logic [1:0] wr_kind, wr_pattern, wr_swing;
  logic st_req, st_gnt = 1'b0, st_err = 1'b0;
  logic [3:0] st_cr_lock = '0, st_eq_ok = '0;
  logic [1:0] st_swing = '0;
  logic done, fail;
  logic [7:0] link_rate;
  logic [2:0] link_lanes;
  logic [1:0] pattern;

  always #2 clk = ~clk;

  lt_train_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_max_rate(src_max_rate), .snk_max_rate(snk_max_rate),
    .src_lanes(src_lanes), .snk_lanes(snk_lanes), .snk_tps3(snk_tps3),
    .wait_cycles(wait_cycles),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_kind(wr_kind),
    .wr_pattern(wr_pattern), .wr_swing(wr_swing),
    .st_req(st_req), .st_gnt(st_gnt), .st_err(st_err),
    .st_cr_lock(st_cr_lock), .st_eq_ok(st_eq_ok), .st_swing(st_swing),
    .done(done), .fail(fail), .link_rate(link_rate), .link_lanes(link_lanes),
    .pattern(pattern));

  int checks = 0, fails = 0, cyc = 0;
  resp_t resp_q[$];
  wexp_t exp_q[$];
  bit exp_ok;
  int exp_rate, exp_lanes;
  bit exp_done = 0, exp_fail = 0;
  int exp_pattern = 0;
  bit pend = 0, pend_stop = 0;
  int pend_pat = 0;
  bit chk_on = 0, wait_req = 0, gnt_d = 0;
  int last_acc = 0, req_age = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic bit all_set(input logic [3:0] v, input int n);
    for (int i = 0; i < n; i++) if (!v[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic wexp_t mk(input int k, input int p, input int s, input int r);
    wexp_t w;
    w.kind = 2'(k); w.pat = 2'(p); w.sw = 2'(s); w.rate = 8'(r);
    return w;
  endfunction

  // Behavioural model: walks the response script and lists expected beats
  task automatic predict();
    int rate, lanes, sw, same, idx, tries, pat, nsw;
    bit maxf, cr_ok, ok, fin;
    resp_t r;
    rate  = (src_max_rate < snk_max_rate) ? int'(src_max_rate) : int'(snk_max_rate);
    lanes = (src_lanes < snk_lanes) ? int'(src_lanes) : int'(snk_lanes);
    idx = 0; ok = 0; fin = 0; sw = 0;
    while (!fin) begin
      exp_q.push_back(mk(0, 1, 0, rate));
      sw = 0; same = 1; maxf = 0; cr_ok = 0;
      while (1) begin
        r = (idx < resp_q.size()) ? resp_q[idx] : resp_t'({1'b1, 10'd0});
        idx++;
        if (r.err) break;
        if (all_set(r.cr, lanes)) begin cr_ok = 1; break; end
        if (same >= 5 || maxf) break;
        nsw = (r.sw >= 2) ? 2 : int'(r.sw);
        same = (nsw == sw) ? same + 1 : 1;
        maxf = (r.sw >= 2);
        sw = nsw;
        exp_q.push_back(mk(1, 1, sw, rate));
      end
      if (cr_ok) begin
        pat = snk_tps3 ? 3 : 2;
        exp_q.push_back(mk(0, pat, sw, rate));
        tries = 0;
        while (1) begin
          r = (idx < resp_q.size()) ? resp_q[idx] : resp_t'({1'b1, 10'd0});
          idx++;
          if (r.err || !all_set(r.cr, lanes)) break;
          if (all_set(r.eq, lanes)) begin ok = 1; break; end
          tries++;
          if (tries == 5) break;
          sw = (r.sw >= 2) ? 2 : int'(r.sw);
          exp_q.push_back(mk(1, pat, sw, rate));
        end
      end
      if (ok || rate == 6) fin = 1;
      else rate = (rate == 8'h14) ? 8'h0A : (rate == 8'h0A) ? 8'h06 : 8'h14;
    end
    exp_q.push_back(mk(2, 0, 0, rate));
    exp_ok = ok; exp_rate = rate; exp_lanes = lanes;
  endtask

  // Sink, write-stream monitor and per-clock comparison
  initial begin
    forever begin
      bit rdy;
      wexp_t w;
      resp_t r;
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
      if (pend) begin
        exp_pattern = pend_pat;
        if (pend_stop) begin exp_done = exp_ok; exp_fail = !exp_ok; end
        pend = 0; pend_stop = 0;
      end
      if (chk_on) begin
        chk(done == exp_done, "R12", "done", int'(done), int'(exp_done));
        chk(fail == exp_fail, "R12", "fail", int'(fail), int'(exp_fail));
        chk(int'(pattern) == exp_pattern, "R2", "pattern output", int'(pattern), exp_pattern);
      end
      rdy = (cyc % 3) != 1;
      if (chk_on && wr_valid && rdy) begin
        if (exp_q.size() == 0) chk(0, "R2", "unexpected beat kind", int'(wr_kind), -1);
        else begin
          w = exp_q.pop_front();
          chk(wr_kind == w.kind, "R3 R8 R9", "beat kind", int'(wr_kind), int'(w.kind));
          chk(wr_pattern == w.pat, "R3 R8", "beat pattern", int'(wr_pattern), int'(w.pat));
          if (w.kind != 2) chk(wr_swing == w.sw, "R6 R7", "beat swing", int'(wr_swing), int'(w.sw));
          chk(link_rate == w.rate, "R11", "rate at beat", int'(link_rate), int'(w.rate));
          pend = 1; pend_pat = int'(w.pat); pend_stop = (w.kind == 2);
          wait_req = (w.kind != 2); last_acc = cyc;
        end
      end
      wr_ready = rdy;
      if (gnt_d) begin
        st_gnt = 0; gnt_d = 0; req_age = 0;
        st_err = 0; st_cr_lock = '0; st_eq_ok = '0; st_swing = '0;
      end else if (st_req) begin
        if (wait_req) begin
          chk(cyc - last_acc == int'(wait_cycles) + 2, "R4", "poll delay", cyc - last_acc, int'(wait_cycles) + 2);
          wait_req = 0;
        end
        req_age++;
        if (req_age == 2) begin
          r = (resp_q.size() > 0) ? resp_q.pop_front() : resp_t'({1'b1, 10'd0});
          st_err = r.err; st_cr_lock = r.cr; st_eq_ok = r.eq; st_swing = r.sw;
          st_gnt = 1; gnt_d = 1;
        end
      end
    end
  end

  task automatic run(input logic [7:0] sr, input logic [7:0] kr, input logic [2:0] sl,
                     input logic [2:0] kl, input bit t3, input int w, input string name);
    int n;
    @(negedge clk);
    src_max_rate = sr; snk_max_rate = kr; src_lanes = sl; snk_lanes = kl;
    snk_tps3 = t3; wait_cycles = 16'(w);
    predict();
    start = 1;
    @(posedge clk);
    #1 start = 0; exp_done = 0; exp_fail = 0;
    n = 0;
    @(negedge clk);
    chk(int'(link_lanes) == exp_lanes, "R1", {name, " lane count"}, int'(link_lanes), exp_lanes);
    while (!(done || fail) && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(n < 20000, "R12", {name, " completion"}, n, 20000);
    chk(done == exp_ok, "R12", {name, " done"}, int'(done), int'(exp_ok));
    chk(fail == !exp_ok, "R12", {name, " fail"}, int'(fail), int'(!exp_ok));
    chk(int'(link_rate) == exp_rate, "R11", {name, " final rate"}, int'(link_rate), exp_rate);
    chk(exp_q.size() == 0, "R9", {name, " beats left"}, exp_q.size(), 0);
    resp_q.delete();
    exp_q.delete();
  endtask

  function automatic resp_t rs(input bit e, input logic [3:0] c, input logic [3:0] q, input logic [1:0] s);
    resp_t r;
    r.err = e; r.cr = c; r.eq = q; r.sw = s;
    return r;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    chk(!done && !fail && !wr_valid && !st_req && pattern == 2'd0, "R12", "reset state",
        int'({done, fail, wr_valid, st_req}), 0);
    rst_n = 1;
    chk_on = 1;
    @(negedge clk);

    // R1 R5 R6 R8: min of caps, swing changes, pattern 3, no wait
    resp_q = '{rs(0,4'h0,4'h0,2'd1), rs(0,4'h3,4'h0,2'd0), rs(0,4'h3,4'h1,2'd2), rs(0,4'h3,4'h3,2'd0)};
    run(8'h14, 8'h0A, 3'd4, 3'd2, 1, 0, "basic");

    // R6: same swing five times with a swing change in between, final at 0x06
    resp_q = '{rs(0,0,0,1), rs(0,0,0,1), rs(0,0,0,1), rs(0,0,0,0), rs(0,0,0,0),
               rs(0,0,0,0), rs(0,0,0,0), rs(0,0,0,0), rs(0,0,0,0)};
    run(8'h14, 8'h06, 3'd2, 3'd2, 0, 3, "same_swing");

    // R7 R11: max swing (request 3 clamps to 2) then miss, fall back 0x14 to 0x0A
    resp_q = '{rs(0,4'h0,0,2'd3), rs(0,4'h0,0,2'd1), rs(0,4'hF,0,0), rs(0,4'hF,4'hF,0)};
    run(8'h14, 8'h14, 3'd4, 3'd4, 1, 2, "max_swing");

    // R8 R9 R11: pattern 2, five equalization misses, then success at 0x06
    resp_q = '{rs(0,4'h3,0,0), rs(0,4'h3,4'h1,1), rs(0,4'h3,4'h1,1), rs(0,4'h3,4'h1,2),
               rs(0,4'h3,4'h1,2), rs(0,4'h3,4'h1,2), rs(0,4'h3,0,0), rs(0,4'h3,4'h3,0)};
    run(8'h0A, 8'h14, 3'd2, 3'd4, 0, 1, "eq_limit");

    // R9: lock lost during equalization at 0x06 is final
    resp_q = '{rs(0,4'h1,0,0), rs(0,4'h0,4'h1,0)};
    run(8'h06, 8'h0A, 3'd1, 3'd4, 1, 2, "lock_lost");

    // R10 R5: error read, then single lane with upper bits clear
    resp_q = '{rs(1,4'hF,4'hF,0), rs(0,4'h1,0,0), rs(0,4'h1,4'h1,0)};
    run(8'h0A, 8'h0A, 3'd1, 3'd2, 0, 4, "err_read");

    // R11: unrecognised code maps to 0x14
    resp_q = '{rs(1,0,0,0), rs(0,4'hF,0,0), rs(0,4'hF,4'hF,0)};
    run(8'h1E, 8'h1E, 3'd4, 3'd4, 1, 1, "odd_rate");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule